// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block lets software on one processor send an interrupt message to another processor, or to every processor at once. It has a register port with word addresses. Two 32-bit registers sit on that port. The high command word holds the destination processor number. The low command word holds the vector, the delivery mode, the trigger mode, the level and the shorthand. A write to the low word starts a send. A write to the high word only prepares the destination for the next send.

The message leaves the block on a valid/ready output. While a message waits for the interconnect to take it, the low word reads back with a busy flag set. Any further attempt to start a send during that time is dropped. The flag clears on the same clock edge that completes the handshake. Software can poll that flag to learn when the next command may be written.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid is 0, and both command words (low at word index 0xC0, high at word index 0xC4) read as 0.
- R2: A write to the high word stores write-data bits [31:24] as the destination. That word reads back with only bits [31:24] non-zero, and the write does not raise msg_valid.
- R3: A low-word write while idle raises msg_valid on the next cycle. The message then carries: vector = bits [7:0], delivery mode = bits [10:8] (3'b101 INIT and 3'b110 STARTUP pass through unchanged), assert = bit 14, level-trigger = bit 15, shorthand = bits [19:18]. The low word reads back these bits as written.
- R4: Low-word bit 12 reads 1 exactly while a message is pending and 0 otherwise. Software cannot write it.
- R5: While msg_valid is 1 and msg_ready is 0, every message field stays unchanged.
- R6: The clock edge on which msg_valid and msg_ready are both 1 clears msg_valid and the busy flag.
- R7: A low-word write while a message is pending is ignored: the message and the low-word readback are unchanged.
- R8: The destination is captured when the low word is written. A high-word write while a message is pending leaves msg_dest unchanged and applies to the next send.
- R9: With shorthand 2'b10 (all processors, sender included), msg_dest is 8'hFF whatever the high word holds. Other shorthand values send the stored destination.
- R10: Writes to other word indices have no effect, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Interconnect accepts the message |
| msg_dest | output | 8 | Destination processor (all ones for broadcast) |
| msg_vector | output | 8 | Vector, or start page for STARTUP |
| msg_mode | output | 3 | Delivery mode |
| msg_level_trig | output | 1 | 1 = level triggered, 0 = edge triggered |
| msg_assert | output | 1 | 1 = assert, 0 = deassert |
| msg_shorthand | output | 2 | Destination shorthand |

## Verification
The assertions assume one register access per cycle, with reg_addr and reg_wr_en at known values from the first edge after reset onward. They also assume msg_ready is an ordinary input that may change at any cycle. Nothing assumes the interconnect accepts within a bounded time. The bench follows these assumptions. It changes every input one nanosecond after a rising edge and holds it until the next edge. It issues writes one at a time. It holds msg_ready low for several cycles before some accepts. For other sends it raises msg_ready before the message appears, so the design is exercised with both slow and immediate acceptance.

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
  parameter int ADDR_W    = 8,
  parameter int LO_OFFSET = 'h300,
  parameter int HI_OFFSET = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level_trig,
  output logic              msg_assert,
  output logic [1:0]        msg_shorthand
);
  localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(LO_OFFSET >> 2);
  localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(HI_OFFSET >> 2);
  localparam logic [1:0]        SH_ALL = 2'b10;

  logic [7:0] hi_dest, dest_q, vec_q;
  logic [2:0] mode_q;
  logic       lvl_q, asrt_q, busy;
  logic [1:0] sh_q;

  wire lo_wr = reg_wr_en && (reg_addr == LO_IDX);
  wire hi_wr = reg_wr_en && (reg_addr == HI_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_dest <= '0;
      dest_q  <= '0;
      vec_q   <= '0;
      mode_q  <= '0;
      lvl_q   <= 1'b0;
      asrt_q  <= 1'b0;
      sh_q    <= '0;
      busy    <= 1'b0;
    end else begin
      if (hi_wr) hi_dest <= reg_wdata[31:24];
      if (lo_wr && !busy) begin
        vec_q  <= reg_wdata[7:0];
        mode_q <= reg_wdata[10:8];
        asrt_q <= reg_wdata[14];
        lvl_q  <= reg_wdata[15];
        sh_q   <= reg_wdata[19:18];
        dest_q <= hi_dest;
        busy   <= 1'b1;
      end else if (busy && msg_ready) begin
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == LO_IDX) begin
      reg_rdata[7:0]   = vec_q;
      reg_rdata[10:8]  = mode_q;
      reg_rdata[12]    = busy;
      reg_rdata[14]    = asrt_q;
      reg_rdata[15]    = lvl_q;
      reg_rdata[19:18] = sh_q;
    end else if (reg_addr == HI_IDX) begin
      reg_rdata[31:24] = hi_dest;
    end
  end

  assign msg_valid      = busy;
  assign msg_dest       = (sh_q == SH_ALL) ? 8'hFF : dest_q;
  assign msg_vector     = vec_q;
  assign msg_mode       = mode_q;
  assign msg_level_trig = lvl_q;
  assign msg_assert     = asrt_q;
  assign msg_shorthand  = sh_q;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_IDX = '0,
  parameter logic [ADDR_W-1:0] HI_IDX = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_dest,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic              msg_level_trig,
  input logic              msg_assert,
  input logic [1:0]        msg_shorthand
);
  wire [22:0] msg_all = {msg_dest, msg_shorthand, msg_level_trig, msg_assert, msg_mode, msg_vector};

  // R3
  start_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && reg_wr_en && reg_addr == LO_IDX |=> msg_valid);

  // R2
  hi_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && reg_wr_en && reg_addr == HI_IDX |=> !msg_valid);

  // R4
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == LO_IDX |-> reg_rdata[12] == msg_valid);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_all));

  // R6
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready && reg_wr_en && reg_addr == LO_IDX |=> $stable(msg_vector) && $stable(msg_mode));
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.ADDR_W(ADDR_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
  .msg_mode(msg_mode), .msg_level_trig(msg_level_trig), .msg_assert(msg_assert),
  .msg_shorthand(msg_shorthand));

// File: tb/ipi_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module ipi_cmd_unit_tb_top;
  localparam int AW = 8;
  localparam logic [AW-1:0] LO = 8'hC0;
  localparam logic [AW-1:0] HI = 8'hC4;

  logic clk = 0, rst_n = 0, reg_wr_en = 0, msg_ready = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_level_trig, msg_assert;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_mode;
  logic [1:0] msg_shorthand;

  int errors = 0, checks = 0;
  logic [22:0] exp_q[$];
  logic done = 0;

  always #5 clk = ~clk;

  ipi_cmd_unit #(.ADDR_W(AW)) dut_i (.*);

  wire [22:0] msg_now = {msg_dest, msg_shorthand, msg_level_trig, msg_assert, msg_mode, msg_vector};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] pack(input logic [7:0] d, input logic [1:0] sh, input logic lv,
                                       input logic as, input logic [2:0] md, input logic [7:0] v);
    return {(sh == 2'b10) ? 8'hFF : d, sh, lv, as, md, v};
  endfunction

  function automatic logic [31:0] lo_word(input logic [1:0] sh, input logic lv,
                                          input logic as, input logic [2:0] md, input logic [7:0] v);
    return {12'h0, sh, 2'b00, lv, as, 3'b000, md, v};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] w, input logic [22:0] e);
    exp_q.push_back(e);
    wr(LO, w);
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected message", {9'h0, msg_now}, 32'h0);
      else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        chk(msg_now == e, "R3/R8/R9 accepted message", {9'h0, msg_now}, {9'h0, e});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      chk(0, "watchdog", 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w1;
    logic [22:0] e1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1
    chk(msg_valid == 0, "R1 valid after reset", {31'h0, msg_valid}, 0);
    rd(LO, r); chk(r == 0, "R1 low word after reset", r, 0);
    rd(HI, r); chk(r == 0, "R1 high word after reset", r, 0);

    // R2
    wr(HI, 32'h05FF_FFFF);
    rd(HI, r); chk(r == 32'h0500_0000, "R2 high word readback", r, 32'h0500_0000);
    @(posedge clk); #1;
    chk(msg_valid == 0, "R2 high write does not send", {31'h0, msg_valid}, 0);

    // R3 INIT, held by interconnect
    w1 = lo_word(2'b00, 1, 1, 3'b101, 8'h20);
    e1 = pack(8'h05, 2'b00, 1, 1, 3'b101, 8'h20);
    send(w1 | 32'h0000_1000, e1);
    chk(msg_valid == 1, "R3 valid after low write", {31'h0, msg_valid}, 1);
    rd(LO, r); chk(r == (w1 | 32'h1000), "R3/R4 low readback with busy", r, w1 | 32'h1000);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(msg_valid && msg_now == e1, "R5 held while not ready", {9'h0, msg_now}, {9'h0, e1});
    end
    // R7
    wr(LO, lo_word(2'b01, 0, 0, 3'b110, 8'h77));
    rd(LO, r); chk(r == (w1 | 32'h1000), "R7 busy write ignored readback", r, w1 | 32'h1000);
    chk(msg_now == e1, "R7 busy write ignored message", {9'h0, msg_now}, {9'h0, e1});
    // R8
    wr(HI, 32'h0900_0000);
    chk(msg_dest == 8'h05, "R8 pending dest unchanged", {24'h0, msg_dest}, 32'h05);
    // R6
    msg_ready = 1;
    @(posedge clk); #1;
    msg_ready = 0;
    chk(msg_valid == 0, "R6 valid clears on accept", {31'h0, msg_valid}, 0);
    rd(LO, r); chk(r[12] == 0, "R4 busy clear after accept", {31'h0, r[12]}, 0);

    // R3 STARTUP with page number, immediate ready; R8 new destination
    msg_ready = 1;
    send(lo_word(2'b00, 0, 1, 3'b110, 8'h9F), pack(8'h09, 2'b00, 0, 1, 3'b110, 8'h9F));
    chk(msg_valid == 1, "R3 startup pending", {31'h0, msg_valid}, 1);
    @(posedge clk); #1;
    chk(msg_valid == 0, "R6 immediate accept", {31'h0, msg_valid}, 0);

    // R9 broadcast
    send(lo_word(2'b10, 1, 0, 3'b101, 8'h30), pack(8'h09, 2'b10, 1, 0, 3'b101, 8'h30));
    msg_ready = 0;
    chk(msg_dest == 8'hFF, "R9 broadcast dest all ones", {24'h0, msg_dest}, 32'hFF);
    msg_ready = 1;
    @(posedge clk); #1;
    // R9 self shorthand keeps destination
    send(lo_word(2'b01, 0, 0, 3'b000, 8'h41), pack(8'h09, 2'b01, 0, 0, 3'b000, 8'h41));
    chk(msg_dest == 8'h09, "R9 non-broadcast dest", {24'h0, msg_dest}, 32'h09);
    @(posedge clk); #1;
    msg_ready = 0;

    // R10
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'hC1, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk(msg_valid == 0, "R10 unmapped write no send", {31'h0, msg_valid}, 0);
    rd(8'hC1, r); chk(r == 0, "R10 unmapped read zero", r, 0);
    rd(HI, r); chk(r == 32'h0900_0000, "R10 high word untouched", r, 32'h0900_0000);

    chk(exp_q.size() == 0, "R3 all messages delivered", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule